// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulator

This block multiplies two signed operands on every enabled clock and folds the product into a running accumulator. A per-cycle select chooses whether the product is added or subtracted, and a single-bit carry-in is added to every update. A load strobe discards the old accumulator contents and starts a new sum from the product plus an externally supplied value. Filters, correlators and dot-product engines use it by streaming operand pairs and pulsing the load strobe at the start of each new sum.

The pipeline depth is a parameter from 1 to 4 register stages. The last stage is always the accumulator register. Any earlier stages hold the operands, the product and the control bits, so a deeper setting shortens the combinational path per stage. A low clock enable freezes every register. An active-high synchronous clear returns the whole pipeline to zero.

Top module: `macc_core`

## Requirements
- R1: The product of `op_a` and `op_b`, both two's complement, is sign-extended to `P_W` bits before accumulation, and every result wraps modulo 2^P_W.
- R2: With `add_sel` = 1 and `load_en` = 0, the accumulator becomes its previous value plus the product plus `cin`.
- R3: With `add_sel` = 0 and `load_en` = 0, the accumulator becomes its previous value minus the product plus `cin`.
- R4: `cin` (0 or 1) is added into every accumulator update, including a load.
- R5: With `load_en` = 1, the accumulator becomes product + `load_val` + `cin`, whatever its previous contents and whatever `add_sel` is.
- R6: With latency parameter `LAT` (1 to 4), an input set presented before enabled rising edge n is reflected on `acc_out` right after enabled edge n+LAT-1.
- R7: While `en` = 0, no register changes: `acc_out` holds, and inputs presented during those cycles have no effect on any later output.
- R8: `srst` = 1 at a rising edge clears the accumulator and all pipeline stages to zero, whatever the values of `en` and `load_en`.
- R9: `srst` acts only at a rising clock edge. Raising it between edges leaves `acc_out` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear, active high |
| en | input | 1 | Clock enable, active high |
| add_sel | input | 1 | 1 adds the product, 0 subtracts it |
| load_en | input | 1 | Restart the sum from load_val |
| cin | input | 1 | Carry-in added on every update |
| op_a | input | A_W | Signed multiplicand |
| op_b | input | B_W | Signed multiplier |
| load_val | input | P_W | Starting value used on a load |
| acc_out | output | P_W | Accumulator value |

## Verification
The bench uses 4-bit and 3-bit operands and a 10-bit accumulator. With these widths it can apply every operand pair under every add/subtract and carry-in combination, and the 10-bit sum wraps after only a few dozen updates, so overflow is reached as well. Three copies run side by side with latency 1, 3 and 4 on identical stimulus. Each copy is compared against one arithmetic model that is shifted by its own depth, so one sweep covers the pass-through, partial and fully staged pipeline arrangements, including enable gaps and clears in the middle of the stream.

// File: rtl/macc_pkg.sv
package macc_pkg;

  typedef struct packed {
    logic add;
    logic load;
    logic cin;
  } macc_ctl_t;

  localparam int CTL_W = $bits(macc_ctl_t);

  // stages ahead of the multiplier that hold the raw operands
  function automatic int opnd_stages(int lat);
    return (lat >= 2) ? 1 : 0;
  endfunction

  // stages between multiplier and accumulator
  function automatic int prod_stages(int lat);
    return (lat - 1) - opnd_stages(lat);
  endfunction

endpackage

// File: rtl/macc_dly.sv
module macc_dly #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (N == 0) begin : g_wire
      assign q = d;
    end else begin : g_reg
      logic [W-1:0] stg_q [N];
      logic [W-1:0] stg_d [N];

      for (genvar i = 0; i < N; i++) begin : g_stg
        if (i == 0) begin : g_head
          always_comb stg_d[i] = d;
        end else begin : g_tail
          always_comb stg_d[i] = stg_q[i-1];
        end

        always_ff @(posedge clk) begin
          if (srst) begin
            stg_q[i] <= '0;
          end else if (en) begin
            stg_q[i] <= stg_d[i];
          end
        end
      end

      assign q = stg_q[N-1];

      AST_DLY_HOLD: assert property (@(posedge clk) disable iff (srst)
        (!en) |=> $stable(q)) else $error("delay line moved while disabled"); // R7
    end
  endgenerate

endmodule

// File: rtl/macc_mult.sv
module macc_mult #(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic [P_W-1:0] prod
);

  localparam int FW = A_W + B_W;

  logic signed [FW-1:0] a_x;
  logic signed [FW-1:0] b_x;
  logic signed [FW-1:0] full;

  always_comb begin
    a_x  = FW'($signed(op_a));
    b_x  = FW'($signed(op_b));
    full = a_x * b_x;
  end

  generate
    if (P_W > FW) begin : g_ext
      assign prod = {{(P_W-FW){full[FW-1]}}, full};
    end else if (P_W == FW) begin : g_same
      assign prod = full;
    end else begin : g_trunc
      assign prod = full[P_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/macc_accum.sv
module macc_accum
  import macc_pkg::*;
#(
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           srst,
  input  logic           en,
  input  macc_ctl_t      ctl,
  input  logic [P_W-1:0] prod,
  input  logic [P_W-1:0] load_val,
  output logic [P_W-1:0] acc_q
);

  logic [P_W-1:0] base;
  logic [P_W-1:0] sum;
  logic [P_W-1:0] acc_d;

  always_comb begin
    base = ctl.load ? load_val : acc_q;
    if (ctl.load || ctl.add) begin
      sum = base + prod;
    end else begin
      sum = base - prod;
    end
    acc_d = sum + P_W'(ctl.cin);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (srst)
    (!en) |=> $stable(acc_q)) else $error("accumulator moved while disabled"); // R7

  AST_ACC_CLEAR: assert property (@(posedge clk)
    srst |=> (acc_q == '0)) else $error("clear did not zero accumulator"); // R8

  AST_ZERO_TERM: assert property (@(posedge clk) disable iff (srst)
    (en && !ctl.load && !ctl.cin && prod == '0) |=> $stable(acc_q))
    else $error("zero product changed accumulator"); // R2

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (srst)
    (en && ctl.load && !ctl.cin && prod == '0 && load_val == '0) |=> (acc_q == '0))
    else $error("load kept old contents"); // R5

endmodule

// File: rtl/macc_core.sv
module macc_core
  import macc_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48,
  parameter int LAT = 3
) (
  input  logic           clk,
  input  logic           srst,
  input  logic           en,
  input  logic           add_sel,
  input  logic           load_en,
  input  logic           cin,
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  input  logic [P_W-1:0] load_val,
  output logic [P_W-1:0] acc_out
);

  localparam int FW    = A_W + B_W;
  localparam int PRE_N = LAT - 1;
  localparam int OPN_N = opnd_stages(LAT);
  localparam int PRD_N = prod_stages(LAT);
  localparam int SIDE_W = CTL_W + P_W;

  macc_ctl_t      ctl_in;
  macc_ctl_t      ctl_s;
  logic [P_W-1:0] ldv_s;
  logic [A_W-1:0] a_s;
  logic [B_W-1:0] b_s;
  logic [P_W-1:0] prod_w;
  logic [P_W-1:0] prod_s;
  logic [SIDE_W-1:0] side_q;
  logic [FW-1:0]     opnd_q;

  assign ctl_in = '{add: add_sel, load: load_en, cin: cin};

  macc_dly #(.W(FW), .N(OPN_N)) u_opnd (
    .clk (clk),
    .srst(srst),
    .en  (en),
    .d   ({op_a, op_b}),
    .q   (opnd_q)
  );
  assign {a_s, b_s} = opnd_q;

  macc_dly #(.W(SIDE_W), .N(PRE_N)) u_side (
    .clk (clk),
    .srst(srst),
    .en  (en),
    .d   ({ctl_in, load_val}),
    .q   (side_q)
  );
  assign {ctl_s, ldv_s} = side_q;

  macc_mult #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mult (
    .op_a(a_s),
    .op_b(b_s),
    .prod(prod_w)
  );

  macc_dly #(.W(P_W), .N(PRD_N)) u_prod (
    .clk (clk),
    .srst(srst),
    .en  (en),
    .d   (prod_w),
    .q   (prod_s)
  );

  macc_accum #(.P_W(P_W)) u_acc (
    .clk     (clk),
    .srst    (srst),
    .en      (en),
    .ctl     (ctl_s),
    .prod    (prod_s),
    .load_val(ldv_s),
    .acc_q   (acc_out)
  );

  generate
    if (P_W >= FW) begin : g_sign_chk
      AST_PROD_SIGN: assert property (@(posedge clk) disable iff (srst)
        (a_s != '0 && b_s != '0) |-> (prod_w[P_W-1] == (a_s[A_W-1] ^ b_s[B_W-1])))
        else $error("product sign wrong"); // R1
    end
  endgenerate

endmodule

// File: tb/macc_core_bench.sv
`timescale 1ns/1ps
module macc_core_bench;

  localparam int A_W = 4;
  localparam int B_W = 3;
  localparam int P_W = 10;
  localparam int MASK = (1 << P_W) - 1;

  logic clk = 1'b0;
  logic srst, en, add_sel, load_en, cin;
  logic [A_W-1:0] op_a;
  logic [B_W-1:0] op_b;
  logic [P_W-1:0] load_val;
  logic [P_W-1:0] acc_l1, acc_l3, acc_l4;

  int n_chk = 0;
  int n_bad = 0;
  int m = 0;
  int mv [0:4095];
  bit done = 0;

  always #10 clk = ~clk;

  macc_core #(.A_W(A_W), .B_W(B_W), .P_W(P_W), .LAT(3)) u_macc_core (
    .clk(clk), .srst(srst), .en(en), .add_sel(add_sel), .load_en(load_en),
    .cin(cin), .op_a(op_a), .op_b(op_b), .load_val(load_val), .acc_out(acc_l3));

  macc_core #(.A_W(A_W), .B_W(B_W), .P_W(P_W), .LAT(1)) u_macc_core_l1 (
    .clk(clk), .srst(srst), .en(en), .add_sel(add_sel), .load_en(load_en),
    .cin(cin), .op_a(op_a), .op_b(op_b), .load_val(load_val), .acc_out(acc_l1));

  macc_core #(.A_W(A_W), .B_W(B_W), .P_W(P_W), .LAT(4)) u_macc_core_l4 (
    .clk(clk), .srst(srst), .en(en), .add_sel(add_sel), .load_en(load_en),
    .cin(cin), .op_a(op_a), .op_b(op_b), .load_val(load_val), .acc_out(acc_l4));

  function automatic int expv(int lat);
    int idx;
    idx = m - lat + 1;
    return (idx <= 0) ? 0 : mv[idx];
  endfunction

  task automatic cmp(string tag, int lat, int got, int want);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s (R6 latency %0d): got %0d expected %0d", tag, lat, got, want);
    end
  endtask

  task automatic chk(string tag);
    cmp(tag, 1, int'(acc_l1), expv(1));
    cmp(tag, 3, int'(acc_l3), expv(3));
    cmp(tag, 4, int'(acc_l4), expv(4));
  endtask

  task automatic step(int a, int b, bit add, bit ci, bit ld, int ldv,
                      bit cen, bit rs, string tag);
    int v;
    op_a = A_W'(a); op_b = B_W'(b); add_sel = add; cin = ci;
    load_en = ld; load_val = P_W'(ldv); en = cen; srst = rs;
    @(posedge clk);
    if (rs) begin
      m = 0;
    end else if (cen) begin
      m++;
      if (ld)       v = a * b + ldv + int'(ci);
      else if (add) v = mv[m-1] + a * b + int'(ci);
      else          v = mv[m-1] - a * b + int'(ci);
      mv[m] = v & MASK;
    end
    @(negedge clk);
    chk(tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    int cnt;
    int hold;
    mv[0] = 0;
    srst = 1; en = 0; add_sel = 0; load_en = 0; cin = 0;
    op_a = '0; op_b = '0; load_val = '0;
    @(negedge clk);
    // reset state R8
    step(0, 0, 0, 0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R8");

    // full sweep of operand pairs, modes, with loads and enable gaps
    cnt = 0;
    for (int a = -8; a < 8; a++) begin
      for (int b = -4; b < 4; b++) begin
        for (int md = 0; md < 4; md++) begin
          bit ld_now, ce_now;
          string tg;
          ld_now = (cnt % 29) == 3;
          ce_now = (cnt % 13) != 5;
          if (!ce_now)      tg = "R7";
          else if (ld_now)  tg = "R5";
          else if (md[1])   tg = "R4";
          else if (md[0])   tg = "R2";
          else              tg = "R3";
          step(a, b, md[0], md[1], ld_now, (cnt * 37) & MASK, ce_now, 0, tg);
          cnt++;
        end
      end
    end

    // load sweep: acc equals sign-extended product
    for (int a = -8; a < 8; a++) begin
      for (int b = -4; b < 4; b++) begin
        step(a, b, 0, 0, 1, 0, 1, 0, "R1");
      end
    end

    // load with carry, add_sel low must not matter
    step(-5, 3, 0, 1, 1, 200, 1, 0, "R5");
    step(7, -4, 0, 1, 1, 17, 1, 0, "R4");

    // wrap above and below
    step(7, 3, 1, 0, 1, 1020, 1, 0, "R1");
    for (int k = 0; k < 8; k++) step(-8, -4, 1, 1, 0, 0, 1, 0, "R1");
    step(0, 0, 0, 0, 1, 3, 1, 0, "R1");
    for (int k = 0; k < 8; k++) step(-8, 3, 1, 0, 0, 0, 1, 0, "R1");

    // long enable gap with changing inputs
    for (int k = 0; k < 6; k++) step(k - 3, 2, k[0], 1, k[1], 99, 0, 0, "R7");
    for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 0, 0, 1, 0, "R6");

    // clear wins over disabled enable and load
    step(6, 3, 1, 1, 1, 500, 0, 1, "R8");
    step(6, 3, 1, 1, 1, 500, 1, 1, "R8");
    for (int k = 0; k < 5; k++) step(3, -2, 1, 0, 0, 0, 1, 0, "R6");

    // clear is only sampled at an edge
    step(5, 3, 1, 0, 1, 77, 1, 0, "R9");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 0, 1, 0, "R9");
    hold = int'(acc_l3);
    srst = 1;
    #5;
    cmp("R9", 3, int'(acc_l3), hold);
    @(posedge clk);
    m = 0;
    @(negedge clk);
    chk("R8");
    step(2, 2, 1, 0, 0, 0, 1, 0, "R6");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 0, 1, 0, "R6");

    done = 1;
    finish_run();
  end

endmodule